// File: doc/BRIEF.md
# Watchdog Countdown Timer with Indexed Registers

This block is a countdown watchdog. Software reaches it through four 8-bit registers, each chosen by an index byte. A single-cycle write strobe carries the data, and the selected register is read back one cycle later. Software writes a timeout value and the counter loads it. The counter then steps down once per unit tick. The unit is either a seconds tick or a minute tick, and the minute tick is made by an internal divide-by-60 prescaler. The seconds tick comes from an internal tick enable or from an external clock-tick input, as a control bit selects.

When the count steps from one to zero, or when software forces an expiry, the block does three things. It sets a status flag, which is also the interrupt output. It drives a reset pulse of fixed length. If a separate routing bit is set, it also raises a system-management interrupt request. Interrupt events from three sources (infrared receiver, keyboard and mouse) can each be enabled to reload the counter with the programmed timeout. Another control bit makes the status flag sticky, so that a bus reset does not clear it.

Top module: `wdt_top`

## Requirements
- R1: After synchronous reset every register reads 0x00, and `rst_pulse`, `irq` and `smi` are low.
- R2: A write to index 0x73 loads the counter with the written value and clears the minute prescaler. A read of index 0x73 returns the live count.
- R3: With index 0x72 bit 7 set (seconds unit), each unit tick lowers a non-zero count by exactly one.
- R4: With index 0x72 bit 7 clear (minutes unit), the count drops by one every 60th tick, counted from the last load or reload.
- R5: When the count steps from one to zero, the status flag (index 0x71 bit 0) and `irq` go high on that same clock edge. A count of zero stays at zero, and a timeout value of zero never expires.
- R6: `rst_pulse` rises on the edge where expiry is detected and stays high for exactly 16 clock cycles.
- R7: Writing one to index 0x71 bit 1 causes an expiry one cycle later. That bit reads back as one for a single cycle and then clears itself.
- R8: Index 0x71 bits 7, 6 and 5 enable reloading the counter with the timeout value on `evt_cir`, `evt_mouse` and `evt_kbd` respectively. An event whose enable bit is clear leaves the count unchanged.
- R9: Writing one to index 0x71 bit 0 clears the status flag. Writing zero to that bit leaves it set.
- R10: While index 0x71 bit 4 is clear, `bus_rst` clears the status flag. While that bit is set, `bus_rst` leaves the flag set.
- R11: Index 0x71 bit 3 selects the count clock. When it is one the counter counts `ext_tick` and ignores `sec_tick`. When it is zero the counter counts `sec_tick`.
- R12: `smi` equals the status flag ANDed with index 0xF1 bit 2.
- R13: Read data is registered and appears one cycle after the index. Bit 2 of index 0x71, all bits except bit 7 of 0x72, all bits except bit 2 of 0xF1, and every unmapped index read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_idx | input | 8 | Register index for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the index of the previous cycle |
| sec_tick | input | 1 | Internal seconds tick enable |
| ext_tick | input | 1 | External clock tick |
| evt_cir | input | 1 | Infrared receiver interrupt event |
| evt_kbd | input | 1 | Keyboard interrupt event |
| evt_mouse | input | 1 | Mouse interrupt event |
| bus_rst | input | 1 | Bus or power-good reset that clears non-sticky status |
| rst_pulse | output | 1 | Fixed-length reset pulse on expiry |
| irq | output | 1 | Watchdog interrupt, equal to the status flag |
| smi | output | 1 | Routed system-management request |

## Verification
A wrong count shows up at the ports in two ways. It is visible within one cycle through a read of index 0x73. It also shifts the cycle on which `irq` and `rst_pulse` rise, which appears only at expiry. A prescaler left uncleared after a reload hides until a minute boundary, so it can take up to 60 ticks to surface as an early decrement. A fault in the status or routing logic appears on `irq` and `smi` in the cycle after the write, event or bus reset that should have changed the flag. The reference model is therefore compared on every clock, and the minute-mode sequence reloads in mid-count to expose a stale prescaler.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] IDX_CTRL = 8'h71;
  localparam logic [REG_W-1:0] IDX_CFG  = 8'h72;
  localparam logic [REG_W-1:0] IDX_TOV  = 8'h73;
  localparam logic [REG_W-1:0] IDX_ROUTE = 8'hF1;

  localparam int B_FORCE = 1;
  localparam int B_STAT  = 0;
  localparam int B_UNIT  = 7;
  localparam int B_SMIEN = 2;

  // stored part of the control register, bits 7..3
  typedef struct packed {
    logic ev_cir;
    logic ev_mouse;
    logic ev_kbd;
    logic sticky;
    logic clk_ext;
  } ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             status,
  output ctrl_t            ctrl,
  output logic             unit_sec,
  output logic             smi_en,
  output logic             force_q,
  output logic             w1c,
  output logic             load,
  output logic [CNT_W-1:0] tov,
  output logic [REG_W-1:0] rdata
);
  logic wr_ctrl, wr_cfg, wr_tov, wr_route;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] cnt_ext;

  always_comb begin
    wr_ctrl  = wr && (idx == IDX_CTRL);
    wr_cfg   = wr && (idx == IDX_CFG);
    wr_tov   = wr && (idx == IDX_TOV);
    wr_route = wr && (idx == IDX_ROUTE);
    w1c      = wr_ctrl && wdata[B_STAT];
    load     = wr_tov;
  end

  always_comb begin
    cnt_ext = '0;
    cnt_ext[CNT_W-1:0] = cnt;
    rd_mux = '0;
    case (idx)
      IDX_CTRL:  rd_mux = {ctrl, 1'b0, force_q, status};
      IDX_CFG:   rd_mux[B_UNIT] = unit_sec;
      IDX_TOV:   rd_mux = cnt_ext;
      IDX_ROUTE: rd_mux[B_SMIEN] = smi_en;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      unit_sec <= 1'b0;
      smi_en   <= 1'b0;
      force_q  <= 1'b0;
      tov      <= '0;
      rdata    <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wdata[7:3]);
      force_q <= wr_ctrl && wdata[B_FORCE];
      if (wr_cfg) unit_sec <= wdata[B_UNIT];
      if (wr_route) smi_en <= wdata[B_SMIEN];
      if (wr_tov) tov <= wdata[CNT_W-1:0];
      rdata <= rd_mux;
    end
  end

  // R7: the force bit never stays set without a fresh write
  assert_force_selfclear_R7: assert property (@(posedge clk) disable iff (rst)
    (force_q && !(wr_ctrl && wdata[B_FORCE])) |=> !force_q);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int MIN_DIV = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic sec_tick,
  input  logic ext_tick,
  input  logic clk_ext,
  input  logic unit_sec,
  input  logic clr,
  output logic unit_tick
);
  localparam int PW = ($clog2(MIN_DIV) > 0) ? $clog2(MIN_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(MIN_DIV - 1);

  logic          src;
  logic [PW-1:0] presc;

  always_comb begin
    src       = clk_ext ? ext_tick : sec_tick;
    unit_tick = unit_sec ? src : (src && (presc == LAST));
  end

  always_ff @(posedge clk) begin
    if (rst || clr || unit_sec) presc <= '0;
    else if (src) presc <= (presc == LAST) ? '0 : presc + 1'b1;
  end

  // R4: in minute mode no unit tick without a source tick
  assert_minute_needs_src_R4: assert property (@(posedge clk) disable iff (rst)
    (!unit_sec && !src) |-> !unit_tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W     = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] tov,
  input  logic             evt_hit,
  input  logic             unit_tick,
  input  logic             force_q,
  input  logic             w1c,
  input  logic             bus_rst,
  input  logic             sticky,
  output logic [CNT_W-1:0] cnt,
  output logic             status,
  output logic             reload,
  output logic             pulse_o
);
  localparam int QW = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic          evt_reload, dec, expire;
  logic [QW-1:0] pulse_cnt;

  always_comb begin
    evt_reload = evt_hit && (tov != '0);
    dec        = unit_tick && (cnt != '0) && !load && !evt_reload;
    expire     = (dec && (cnt == ONE)) || force_q;
    reload     = load || evt_reload;
    pulse_o    = (pulse_cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      status    <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      if (load) cnt <= load_val;
      else if (evt_reload) cnt <= tov;
      else if (dec) cnt <= cnt - 1'b1;

      if (expire) status <= 1'b1;
      else if (w1c || (bus_rst && !sticky)) status <= 1'b0;

      if (expire) pulse_cnt <= QW'(PULSE_LEN);
      else if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  assert_status_on_expire_R5: assert property (@(posedge clk) disable iff (rst)
    expire |=> status);
  assert_zero_holds_R5: assert property (@(posedge clk) disable iff (rst)
    ((cnt == '0) && !load && !evt_reload) |=> (cnt == '0));
  assert_pulse_starts_R6: assert property (@(posedge clk) disable iff (rst)
    expire |=> pulse_o);
  assert_single_step_R3: assert property (@(posedge clk) disable iff (rst)
    dec |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_DIV   = 60,
  parameter int PULSE_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [7:0] reg_idx,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sec_tick,
  input  logic       ext_tick,
  input  logic       evt_cir,
  input  logic       evt_kbd,
  input  logic       evt_mouse,
  input  logic       bus_rst,
  output logic       rst_pulse,
  output logic       irq,
  output logic       smi
);
  ctrl_t            ctrl;
  logic             unit_sec, smi_en, force_q, w1c, load;
  logic [CNT_W-1:0] tov, cnt;
  logic             status, reload, unit_tick, evt_hit;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .cnt(cnt), .status(status), .ctrl(ctrl), .unit_sec(unit_sec),
    .smi_en(smi_en), .force_q(force_q), .w1c(w1c), .load(load),
    .tov(tov), .rdata(reg_rdata)
  );

  wdt_prescale #(.MIN_DIV(MIN_DIV)) u_presc (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .ext_tick(ext_tick),
    .clk_ext(ctrl.clk_ext), .unit_sec(unit_sec), .clr(reload),
    .unit_tick(unit_tick)
  );

  always_comb
    evt_hit = (ctrl.ev_cir && evt_cir) || (ctrl.ev_mouse && evt_mouse) ||
              (ctrl.ev_kbd && evt_kbd);

  wdt_counter #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(reg_wdata[CNT_W-1:0]),
    .tov(tov), .evt_hit(evt_hit), .unit_tick(unit_tick), .force_q(force_q),
    .w1c(w1c), .bus_rst(bus_rst), .sticky(ctrl.sticky), .cnt(cnt),
    .status(status), .reload(reload), .pulse_o(rst_pulse)
  );

  always_comb begin
    irq = status;
    smi = status && smi_en;
  end

  assert_smi_implies_irq_R12: assert property (@(posedge clk) disable iff (rst)
    smi |-> irq);
  assert_sticky_survives_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && ctrl.sticky && bus_rst && !w1c) |=> irq);
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;
  localparam int DIV = 60;
  localparam int PLEN = 16;

  logic clk = 1'b0;
  logic rst, reg_wr, sec_tick, ext_tick, evt_cir, evt_kbd, evt_mouse, bus_rst;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  logic rst_pulse, irq, smi;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_tov, m_presc, m_pulse, m_rdata;
  bit m_cir, m_mouse, m_kbd, m_sticky, m_ext, m_unit, m_smien, m_force, m_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_top u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
    .ext_tick(ext_tick), .evt_cir(evt_cir), .evt_kbd(evt_kbd),
    .evt_mouse(evt_mouse), .bus_rst(bus_rst), .rst_pulse(rst_pulse),
    .irq(irq), .smi(smi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit src, utick, evr, ld, expire, wc, w1;
    int rd;
    if (rst) begin
      m_cnt = 0; m_tov = 0; m_presc = 0; m_pulse = 0; m_rdata = 0;
      {m_cir, m_mouse, m_kbd, m_sticky, m_ext} = '0;
      m_unit = 0; m_smien = 0; m_force = 0; m_status = 0;
      return;
    end
    case (reg_idx)
      8'h71: rd = (m_cir << 7) | (m_mouse << 6) | (m_kbd << 5) | (m_sticky << 4) |
                  (m_ext << 3) | (m_force << 1) | m_status;
      8'h72: rd = m_unit << 7;
      8'h73: rd = m_cnt;
      8'hF1: rd = m_smien << 2;
      default: rd = 0;
    endcase
    src   = m_ext ? ext_tick : sec_tick;
    utick = m_unit ? src : (src && m_presc == DIV - 1);
    ld    = reg_wr && reg_idx == 8'h73;
    wc    = reg_wr && reg_idx == 8'h71;
    evr   = ((m_cir && evt_cir) || (m_mouse && evt_mouse) || (m_kbd && evt_kbd)) && m_tov != 0;
    expire = m_force || (!ld && !evr && utick && m_cnt == 1);
    w1 = wc && reg_wdata[0];
    // next state
    if (ld || evr || m_unit) m_presc = 0;
    else if (src) m_presc = (m_presc == DIV - 1) ? 0 : m_presc + 1;
    if (ld) m_cnt = reg_wdata;
    else if (evr) m_cnt = m_tov;
    else if (utick && m_cnt != 0) m_cnt = m_cnt - 1;
    if (expire) m_status = 1;
    else if (w1 || (bus_rst && !m_sticky)) m_status = 0;
    if (expire) m_pulse = PLEN;
    else if (m_pulse > 0) m_pulse--;
    m_force = wc && reg_wdata[1];
    if (wc) {m_cir, m_mouse, m_kbd, m_sticky, m_ext} = reg_wdata[7:3];
    if (reg_wr && reg_idx == 8'h72) m_unit = reg_wdata[7];
    if (reg_wr && reg_idx == 8'hF1) m_smien = reg_wdata[2];
    if (ld) m_tov = reg_wdata;
    m_rdata = rd;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(reg_rdata == 8'(m_rdata), "R13 model read data", reg_rdata, m_rdata);
    check(irq == m_status, "R5 model irq", irq, m_status);
    check(rst_pulse == (m_pulse != 0), "R6 model pulse", rst_pulse, m_pulse != 0);
    check(smi == (m_status && m_smien), "R12 model smi", smi, m_status && m_smien);
  endtask

  task automatic wr_reg(input logic [7:0] i, input logic [7:0] d);
    reg_wr = 1; reg_idx = i; reg_wdata = d;
    cycle();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_reg(input logic [7:0] i, output logic [7:0] v);
    reg_idx = i;
    cycle();
    v = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      sec_tick = 1;
      cycle();
      sec_tick = 0;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int np;
    rst = 1; reg_wr = 0; reg_idx = 0; reg_wdata = 0; sec_tick = 0; ext_tick = 0;
    evt_cir = 0; evt_kbd = 0; evt_mouse = 0; bus_rst = 0;
    repeat (3) cycle();
    rst = 0;
    // R1 reset state
    rd_reg(8'h71, v); check(v == 8'h00, "R1 ctrl after reset", v, 0);
    rd_reg(8'h73, v); check(v == 8'h00, "R1 count after reset", v, 0);
    check(!irq && !smi && !rst_pulse, "R1 outputs after reset", {irq, smi, rst_pulse}, 0);

    // R2 R3 seconds countdown, R5 R6 expiry
    wr_reg(8'h72, 8'h80);
    wr_reg(8'h73, 8'd5);
    ticks(2);
    rd_reg(8'h73, v); check(v == 8'd3, "R2 R3 count after two ticks", v, 3);
    ticks(2);
    check(irq == 0, "R5 no expiry at count one", irq, 0);
    ticks(1);
    check(irq == 1, "R5 irq on reaching zero", irq, 1);
    np = rst_pulse ? 1 : 0;
    for (int k = 0; k < 20; k++) begin cycle(); if (rst_pulse) np++; end
    check(np == 16, "R6 pulse length", np, 16);
    ticks(3);
    rd_reg(8'h73, v); check(v == 8'd0, "R5 zero count holds", v, 0);
    rd_reg(8'h71, v); check(v == 8'h01, "R5 status bit", v, 1);

    // R9 write-one-to-clear
    wr_reg(8'h71, 8'h00);
    check(irq == 1, "R9 write zero keeps status", irq, 1);
    wr_reg(8'h71, 8'h01);
    check(irq == 0, "R9 write one clears status", irq, 0);

    // R7 force, R12 routing
    wr_reg(8'hF1, 8'h04);
    wr_reg(8'h71, 8'h02);
    rd_reg(8'h71, v); check(v == 8'h02, "R7 force bit reads one", v, 2);
    rd_reg(8'h71, v); check(v == 8'h01, "R7 force cleared, status set", v, 1);
    check(smi == 1, "R12 smi routed", smi, 1);
    wr_reg(8'hF1, 8'h00);
    check(smi == 0 && irq == 1, "R12 smi blocked", {smi, irq}, 1);

    // R10 bus reset vs sticky
    bus_rst = 1; cycle(); bus_rst = 0;
    check(irq == 0, "R10 bus reset clears status", irq, 0);
    wr_reg(8'h71, 8'h12);
    cycle();
    check(irq == 1, "R7 forced expiry", irq, 1);
    bus_rst = 1; cycle(); bus_rst = 0;
    check(irq == 1, "R10 sticky survives bus reset", irq, 1);
    wr_reg(8'h71, 8'h11);
    check(irq == 0, "R9 sticky cleared by write one", irq, 0);

    // R8 event reloads
    wr_reg(8'h71, 8'hA0);
    wr_reg(8'h72, 8'h80);
    wr_reg(8'h73, 8'd10);
    ticks(4);
    evt_mouse = 1; cycle(); evt_mouse = 0;
    rd_reg(8'h73, v); check(v == 8'd6, "R8 disabled mouse event ignored", v, 6);
    evt_cir = 1; cycle(); evt_cir = 0;
    rd_reg(8'h73, v); check(v == 8'd10, "R8 cir reload", v, 10);
    ticks(2);
    evt_kbd = 1; cycle(); evt_kbd = 0;
    rd_reg(8'h73, v); check(v == 8'd10, "R8 kbd reload", v, 10);

    // R4 minute unit and prescaler clear on load
    wr_reg(8'h71, 8'h00);
    wr_reg(8'h72, 8'h00);
    wr_reg(8'h73, 8'd2);
    ticks(59);
    rd_reg(8'h73, v); check(v == 8'd2, "R4 no step before 60 ticks", v, 2);
    ticks(1);
    rd_reg(8'h73, v); check(v == 8'd1, "R4 step at 60th tick", v, 1);
    wr_reg(8'h73, 8'd3);
    ticks(30);
    wr_reg(8'h73, 8'd3);
    ticks(59);
    rd_reg(8'h73, v); check(v == 8'd3, "R2 R4 prescaler cleared by load", v, 3);
    ticks(1);
    rd_reg(8'h73, v); check(v == 8'd2, "R4 step after reload", v, 2);

    // R11 external clock select
    wr_reg(8'h71, 8'h08);
    wr_reg(8'h72, 8'h80);
    wr_reg(8'h73, 8'd3);
    ticks(2);
    rd_reg(8'h73, v); check(v == 8'd3, "R11 internal tick ignored", v, 3);
    ext_tick = 1; cycle(); ext_tick = 0;
    rd_reg(8'h73, v); check(v == 8'd2, "R11 external tick counts", v, 2);

    // R5 zero timeout never expires
    wr_reg(8'h71, 8'h00);
    wr_reg(8'h73, 8'd0);
    ticks(4);
    check(irq == 0, "R5 zero timeout disabled", irq, 0);

    // R13 reserved and unmapped reads
    rd_reg(8'h72, v); check(v == 8'h80, "R13 cfg readback", v, 8'h80);
    wr_reg(8'h71, 8'h04);
    rd_reg(8'h71, v); check(v == 8'h00, "R13 reserved bit reads zero", v, 0);
    rd_reg(8'h55, v); check(v == 8'h00, "R13 unmapped index", v, 0);
    wr_reg(8'hF1, 8'hFF);
    rd_reg(8'hF1, v); check(v == 8'h04, "R13 route register", v, 4);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule